// File: doc/BRIEF.md
# Cable Type Detection Sequencer

This block runs on the device side of a disk interface. When an identify command arrives, it pulls a shared open-drain diagnostic line low for a fixed number of microseconds, then lets go of the line. After a settling window it samples the level the line has returned to. It holds that level as the cable-type bit that the identification data reports. A host capacitor on the line means a 40-conductor cable holds the line low after release, so the sample reads low. An 80-conductor cable leaves the line free for the device pull-up, so the sample reads high.

The block is timed by a one-cycle microsecond tick taken from the system clock domain. The raw line level enters through a synchronizer. The block has one output that enables the open-drain pull-down, one output for the latched cable bit and one done flag. Only a device that supports transfer modes above 2 runs the sequence, and the `hi_mode_cap` input tells the block whether this is so.

Top module: `cable_sense_seq`

## Requirements
- R1: During reset and after it, `line_pull_en`, `sense_done` and `cable_80` are all 0.
- R2: An `id_cmd` pulse seen at a clock edge while `hi_mode_cap` is 1 sets `line_pull_en` to 1 and `sense_done` to 0 at that same edge.
- R3: `line_pull_en` stays 1 through DRIVE_US+1 `us_tick` pulses after the accepted command. It falls at the edge that samples the last of them, so the line is pulled for at least DRIVE_US whole microseconds.
- R4: Once `line_pull_en` has fallen, it stays 0 until the next accepted command. The line is released and is not driven.
- R5: The line is sampled at the edge that takes the SAMPLE_US-th `us_tick` after release, which is 7 µs by default. The sample goes through a two-flop synchronizer. Levels present earlier in the release window have no effect on the result.
- R6: `cable_80` takes the sampled level. A low line gives 0 (40-conductor cable) and a high line gives 1 (80-conductor cable).
- R7: `sense_done` rises at the same edge that loads `cable_80`, while `line_pull_en` is 0. It stays 1 until the next accepted command.
- R8: `cable_80` keeps its value between sequences. Line changes after the sample have no effect on it.
- R9: An accepted `id_cmd` that arrives during the pull phase or the release phase restarts the pull phase with its full length.
- R10: While `hi_mode_cap` is 0, `id_cmd` is ignored. The line is not pulled, and `sense_done` and `cable_80` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| id_cmd | input | 1 | One-cycle pulse when an identify command is received |
| hi_mode_cap | input | 1 | 1 when the device supports transfer modes above 2 |
| line_in | input | 1 | Raw level of the diagnostic line, asynchronous |
| line_pull_en | output | 1 | 1 enables the open-drain pull-down on the line |
| cable_80 | output | 1 | Latched cable-type bit: 1 for 80-conductor, 0 for 40-conductor |
| sense_done | output | 1 | 1 once the cable bit has been latched for the last command |

## Verification
A wrong phase register shows at `line_pull_en` in one of two ways. The pull either starts a cycle late after the command, or it ends on the wrong tick, which shifts the pull width by a whole microsecond. A wrong tick count in the release phase moves the rise of `sense_done` by at least one tick period. It can also pick up a line level that the bench changes partway through the window. The wrong bit is then visible on `cable_80` as soon as `sense_done` rises. Faults in hold or ignore logic do not show until later: they appear on `cable_80` or `sense_done` only after the bench has moved the line or sent an ignored command and waited several ticks.

// File: rtl/cable_sense_pkg.sv
package cable_sense_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PULL    = 2'd1,
        PH_RELEASE = 2'd2
    } sense_phase_e;

    typedef struct packed {
        sense_phase_e phase;
        logic         cable_bit;
        logic         done;
    } sense_regs_t;

    localparam sense_regs_t SENSE_RST = '{phase: PH_IDLE, cable_bit: 1'b0, done: 1'b0};

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/us_timer.sv
module us_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cable_sense_seq.sv
module cable_sense_seq
    import cable_sense_pkg::*;
#(
    parameter int DRIVE_US    = 30,
    parameter int SAMPLE_US   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic id_cmd,
    input  logic hi_mode_cap,
    input  logic line_in,
    output logic line_pull_en,
    output logic cable_80,
    output logic sense_done
);
    localparam int SPAN  = (DRIVE_US > SAMPLE_US) ? DRIVE_US : SAMPLE_US;
    localparam int CNT_W = $clog2(SPAN + 2);
    localparam logic [CNT_W-1:0] PULL_LAST   = CNT_W'(DRIVE_US);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_US - 1);

    sense_regs_t      regs_d;
    sense_regs_t      regs_q;
    logic             timer_clr;
    logic [CNT_W-1:0] tick_cnt;
    logic             line_sync_lvl;
    logic             cmd_take;

    line_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_in),
        .sync_o  (line_sync_lvl)
    );

    us_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (timer_clr),
        .tick_i  (us_tick),
        .count_o (tick_cnt)
    );

    assign cmd_take = id_cmd && hi_mode_cap;

    always_comb begin
        regs_d    = regs_q;
        timer_clr = 1'b0;
        unique case (regs_q.phase)
            PH_PULL: begin
                if (us_tick && tick_cnt == PULL_LAST) begin
                    regs_d.phase = PH_RELEASE;
                    timer_clr    = 1'b1;
                end
            end
            PH_RELEASE: begin
                if (us_tick && tick_cnt == SAMPLE_LAST) begin
                    regs_d.phase     = PH_IDLE;
                    regs_d.cable_bit = line_sync_lvl;
                    regs_d.done      = 1'b1;
                    timer_clr        = 1'b1;
                end
            end
            default: begin
                regs_d.phase = PH_IDLE;
            end
        endcase
        if (cmd_take) begin
            regs_d.phase = PH_PULL;
            regs_d.done  = 1'b0;
            timer_clr    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= SENSE_RST;
        else        regs_q <= regs_d;
    end

    assign line_pull_en = (regs_q.phase == PH_PULL);
    assign cable_80     = regs_q.cable_bit;
    assign sense_done   = regs_q.done;
endmodule

// File: rtl/cable_sense_chk.sv
module cable_sense_chk (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic id_cmd,
    input logic hi_mode_cap,
    input logic line_pull_en,
    input logic cable_80,
    input logic sense_done
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_pull_en && !sense_done && !cable_80));

    // R2
    cmd_starts_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cmd && hi_mode_cap) |=> (line_pull_en && !sense_done));

    // R3
    pull_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull_en) |-> $past(us_tick));

    // R4
    no_pull_without_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pull_en && !(id_cmd && hi_mode_cap)) |=> !line_pull_en);

    // R7
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_done) |-> ($past(us_tick) && !line_pull_en));

    // R7
    done_excl_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_done |-> !line_pull_en);

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sense_done) |-> $stable(cable_80));

    // R10
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_cmd && !hi_mode_cap && !line_pull_en) |=> (!line_pull_en && $stable(sense_done)));
endmodule

bind cable_sense_seq cable_sense_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick      (us_tick),
    .id_cmd       (id_cmd),
    .hi_mode_cap  (hi_mode_cap),
    .line_pull_en (line_pull_en),
    .cable_80     (cable_80),
    .sense_done   (sense_done)
);

// File: tb/cable_sense_seq_tb.sv
module cable_sense_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 5;
    localparam int DRIVE_US   = 30;
    localparam int SAMPLE_US  = 7;
    localparam int GUARD      = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic id_cmd = 1'b0;
    logic hi_mode_cap = 1'b1;
    logic line_lvl = 1'b1;
    logic line_in;
    logic line_pull_en;
    logic cable_80;
    logic sense_done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    assign line_in = line_pull_en ? 1'b0 : line_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    cable_sense_seq #(
        .DRIVE_US    (DRIVE_US),
        .SAMPLE_US   (SAMPLE_US),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .id_cmd       (id_cmd),
        .hi_mode_cap  (hi_mode_cap),
        .line_in      (line_in),
        .line_pull_en (line_pull_en),
        .cable_80     (cable_80),
        .sense_done   (sense_done)
    );

    initial begin
        int div;
        div = 0;
        forever begin
            @(posedge clk);
            #2;
            div = (div == TICK_DIV - 1) ? 0 : div + 1;
            us_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_cmd();
        @(posedge clk);
        #2;
        id_cmd = 1'b1;
        @(posedge clk);
        #2;
        id_cmd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        int seen;
        seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (us_tick) seen++;
        end
    endtask

    task automatic count_pull(output int ticks);
        int g;
        ticks = 0;
        g = 0;
        while (line_pull_en && g < GUARD) begin
            if (us_tick) ticks++;
            @(negedge clk);
            g++;
        end
    endtask

    task automatic count_release(output int ticks);
        int g;
        ticks = 0;
        g = 0;
        while (!sense_done && g < GUARD) begin
            if (us_tick) ticks++;
            @(negedge clk);
            g++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!line_pull_en && !sense_done && !cable_80, "R1 reset outputs",
            {line_pull_en, sense_done, cable_80}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!line_pull_en && !sense_done && !cable_80, "R1 after reset",
            {line_pull_en, sense_done, cable_80}, 0);
    endtask

    task automatic t_full(input logic lvl);
        int pt, rt;
        line_lvl = lvl;
        send_cmd();
        chk(line_pull_en == 1'b1, "R2 pull starts", line_pull_en, 1);
        chk(sense_done == 1'b0, "R2 done cleared", sense_done, 0);
        count_pull(pt);
        chk(pt == DRIVE_US + 1, "R3 pull width ticks", pt, DRIVE_US + 1);
        count_release(rt);
        chk(rt == SAMPLE_US, "R5 release ticks to sample", rt, SAMPLE_US);
        chk(cable_80 == lvl, "R6 cable bit", cable_80, lvl);
        chk(sense_done && !line_pull_en, "R7 done with line free",
            {sense_done, line_pull_en}, 2);
    endtask

    task automatic t_late_change(input logic early, input logic late);
        int pt;
        line_lvl = early;
        send_cmd();
        count_pull(pt);
        wait_ticks(3);
        line_lvl = late;
        wait_ticks(2);
        chk(line_pull_en == 1'b0, "R4 line stays released", line_pull_en, 0);
        begin
            int rt;
            count_release(rt);
        end
        chk(cable_80 == late, "R5 early level ignored", cable_80, late);
    endtask

    task automatic t_hold();
        logic held;
        held = cable_80;
        line_lvl = ~held;
        wait_ticks(20);
        chk(cable_80 == held, "R8 bit holds", cable_80, held);
        chk(sense_done && !line_pull_en, "R8 done holds, no pull",
            {sense_done, line_pull_en}, 2);
    endtask

    task automatic t_restart_pull();
        int pt, rt;
        line_lvl = 1'b1;
        send_cmd();
        wait_ticks(10);
        send_cmd();
        chk(line_pull_en && !sense_done, "R9 restart in pull",
            {line_pull_en, sense_done}, 2);
        count_pull(pt);
        chk(pt == DRIVE_US + 1, "R9 full pull after restart", pt, DRIVE_US + 1);
        count_release(rt);
        chk(cable_80 == 1'b1, "R9 result after restart", cable_80, 1);
    endtask

    task automatic t_restart_release();
        int pt, rt;
        line_lvl = 1'b0;
        send_cmd();
        count_pull(pt);
        wait_ticks(3);
        send_cmd();
        chk(line_pull_en == 1'b1, "R9 restart in release", line_pull_en, 1);
        count_pull(pt);
        chk(pt == DRIVE_US + 1, "R9 full pull from release", pt, DRIVE_US + 1);
        count_release(rt);
        chk(rt == SAMPLE_US && cable_80 == 1'b0, "R9 sample after restart",
            {rt, cable_80}, {SAMPLE_US, 1'b0});
    endtask

    task automatic t_incapable();
        logic held;
        int seen_pull;
        held = cable_80;
        hi_mode_cap = 1'b0;
        line_lvl = ~held;
        send_cmd();
        seen_pull = 0;
        for (int i = 0; i < TICK_DIV * 50; i++) begin
            if (line_pull_en) seen_pull++;
            @(negedge clk);
        end
        chk(seen_pull == 0, "R10 no pull when incapable", seen_pull, 0);
        chk(sense_done == 1'b1, "R10 done kept", sense_done, 1);
        chk(cable_80 == held, "R10 bit kept", cable_80, held);
        hi_mode_cap = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full(1'b1);
        t_hold();
        t_full(1'b0);
        t_hold();
        t_late_change(1'b0, 1'b1);
        t_late_change(1'b1, 1'b0);
        t_restart_pull();
        t_restart_release();
        t_full(1'b1);
        t_incapable();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule